// File: doc/BRIEF.md
# Integer-Factor Line-Repeat Video Upscaler

This block enlarges a small progressive picture, such as a 320 by 240 console image, by a whole-number factor of two, three or four. Each incoming pixel is emitted several times along the line, and each incoming line is emitted several times down the frame. The result is sent with active-high horizontal sync, vertical sync and a data-enable to a downstream display encoder. With the default geometry the factors give 640x480, 960x720 and 1280x960 active areas.

Only two lines of storage are kept, in on-chip RAM, and they are used alternately. The source writes line n into one bank while the output side replays the previous line from the other bank. The delay from input to output is therefore a few lines and not a frame. The output side runs its own timing counters. The source is expected to deliver each line before the output needs it, and the line-start and frame-start markers on the input choose the bank.

There are two display options. A freeze control stops all writes, so the picture held in the banks stays on screen. A scanline option darkens the final copy of every source line. The factor and the scanline option are sampled only when a new output frame begins.

Top module: `line_scaler`

## Requirements
- R1: Within an active output line, every stored pixel appears for exactly F consecutive cycles, where F is the current factor, so data-enable stays high for IN_W*F cycles per line.
- R2: Every stored source line is emitted on F consecutive output lines, giving IN_H*F active lines per frame.
- R3: The factor code on scale_sel maps 0 to 2x, 1 to 3x, and 2 or 3 to 4x.
- R4: An output line lasts IN_W*F+H_FP+H_SW+H_BP cycles. hsync goes high H_FP cycles after the last active pixel and stays high for H_SW cycles. vsync goes high at the start of the V_FP-th line after the last active line and stays high for V_SW lines. Data-enable is never high together with either sync.
- R5: scale_sel and scan_en are sampled only at the boundary between output frames. A change during a frame leaves that frame unchanged.
- R6: With scanlines enabled, the last of the F copies of each source line shows each 8-bit channel (red 23:16, green 15:8, blue 7:0) shifted right by one bit. The other copies are unchanged.
- R7: in_sof with a valid pixel starts line 0 in bank 0. in_sol without in_sof starts the next line in the other bank. Output source line n reads bank n mod 2.
- R8: While freeze is high no input pixel is stored, and the output keeps showing the contents already held.
- R9: Valid pixels past column IN_W-1 of a line are discarded and do not disturb stored data.
- R10: out_pix is zero whenever out_de is low.
- R11: During and straight after reset all outputs are low, the factor is 2x, scanlines are off, and the output timing starts at the top-left corner of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock for both the input and output sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| scale_sel | input | 2 | Factor code (0: 2x, 1: 3x, 2/3: 4x) |
| scan_en | input | 1 | Darken the last copy of each source line |
| freeze | input | 1 | Block all writes to the line banks |
| in_valid | input | 1 | Input pixel present this cycle |
| in_sof | input | 1 | First pixel of a frame |
| in_sol | input | 1 | First pixel of a line |
| in_pix | input | 24 | Input RGB pixel |
| out_pix | output | 24 | Output RGB pixel |
| out_de | output | 1 | Output data-enable |
| out_hsync | output | 1 | Horizontal sync, active high |
| out_vsync | output | 1 | Vertical sync, active high |

## Verification
Assertions run on every cycle. They check that the factor register holds one of the three legal values and changes only at a frame boundary. They check that the per-pixel and per-line repeat counters stay below the factor, that a full line of source pixels and a full frame of source lines have been consumed at the counters' wrap points, that the input column saturates, that frame start selects bank zero, that freeze suppresses every write, and that data-enable never overlaps a sync pulse. Several behaviours can only be shown by the bench's frame sweeps, which compare the pictures against a shadow copy of the two banks: the pixel values themselves, the darkening on the right copy only, the held image under freeze, the discarding of extra pixels, and the exact sync positions and widths for each factor.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef logic [23:0] rgb_t;

  // factor code to repeat count
  function automatic logic [2:0] factor_of(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd2;
      2'd1:    return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  // halve every 8-bit channel
  function automatic rgb_t shade(input rgb_t p);
    return {1'b0, p[23:17], 1'b0, p[15:9], 1'b0, p[7:1]};
  endfunction
endpackage

// File: rtl/lsc_writer.sv
module lsc_writer #(
  parameter int IN_W = 320,
  parameter int AW   = $clog2(IN_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_sol,
  input  logic          freeze,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          wr_bank
);
  localparam int CW = $clog2(IN_W + 1);

  logic [CW-1:0] col_q, col_n;
  logic          bank_q, bank_n, in_range;

  always_comb begin
    col_n    = (in_sof || in_sol) ? '0 : col_q;
    bank_n   = in_sof ? 1'b0 : (in_sol ? ~bank_q : bank_q);
    in_range = col_n < CW'(IN_W);
    wr_en    = in_valid && !freeze && in_range;
    wr_addr  = AW'(col_n);
    wr_bank  = bank_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      bank_q <= 1'b0;
    end else if (in_valid) begin
      bank_q <= bank_n;
      col_q  <= in_range ? col_n + CW'(1) : col_n;
    end
  end

  p_col_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= CW'(IN_W));
  p_sof_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> (bank_q == 1'b0));
endmodule

// File: rtl/lsc_timing.sv
module lsc_timing #(
  parameter int IN_W = 320,
  parameter int IN_H = 240,
  parameter int H_FP = 16,
  parameter int H_SW = 96,
  parameter int H_BP = 48,
  parameter int V_FP = 10,
  parameter int V_SW = 2,
  parameter int V_BP = 33,
  parameter int AW   = $clog2(IN_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    scale_sel,
  input  logic          scan_en,
  output logic          de,
  output logic          hs,
  output logic          vs,
  output logic          dim,
  output logic [AW-1:0] rd_addr,
  output logic          rd_bank
);
  import lsc_pkg::*;
  localparam int HB  = H_FP + H_SW + H_BP;
  localparam int VB  = V_FP + V_SW + V_BP;
  localparam int HW  = $clog2(IN_W * 4 + HB + 1);
  localparam int VW  = $clog2(IN_H * 4 + VB + 1);
  localparam int SXW = $clog2(IN_W + 1);
  localparam int SYW = $clog2(IN_H + 1);

  logic [HW-1:0]  h_q, h_act, h_tot;
  logic [VW-1:0]  v_q, v_act, v_tot;
  logic [2:0]     fac_q, hsub_q, vsub_q;
  logic [SXW-1:0] hsrc_q;
  logic [SYW-1:0] vsrc_q;
  logic           scan_q;
  // named events for the checks
  logic line_end, frame_wrap, h_in, v_in, last_h, last_v;

  always_comb begin
    h_act      = HW'(IN_W * int'(fac_q));
    h_tot      = h_act + HW'(HB);
    v_act      = VW'(IN_H * int'(fac_q));
    v_tot      = v_act + VW'(VB);
    line_end   = (h_q == h_tot - HW'(1));
    frame_wrap = line_end && (v_q == v_tot - VW'(1));
    h_in       = h_q < h_act;
    v_in       = v_q < v_act;
    last_h     = (hsub_q == fac_q - 3'd1);
    last_v     = (vsub_q == fac_q - 3'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0; v_q <= '0; hsub_q <= '0; vsub_q <= '0;
      hsrc_q <= '0; vsrc_q <= '0; fac_q <= 3'd2; scan_q <= 1'b0;
    end else begin
      h_q <= line_end ? '0 : h_q + HW'(1);
      if (line_end) begin
        hsub_q <= '0;
        hsrc_q <= '0;
      end else if (h_in) begin
        if (last_h) begin
          hsub_q <= '0;
          hsrc_q <= hsrc_q + SXW'(1);
        end else begin
          hsub_q <= hsub_q + 3'd1;
        end
      end
      if (line_end) begin
        v_q <= frame_wrap ? '0 : v_q + VW'(1);
        if (frame_wrap) begin
          vsub_q <= '0;
          vsrc_q <= '0;
          fac_q  <= factor_of(scale_sel);
          scan_q <= scan_en;
        end else if (v_in) begin
          if (last_v) begin
            vsub_q <= '0;
            vsrc_q <= vsrc_q + SYW'(1);
          end else begin
            vsub_q <= vsub_q + 3'd1;
          end
        end
      end
    end
  end

  always_comb begin
    de      = h_in && v_in;
    hs      = (h_q >= h_act + HW'(H_FP)) && (h_q < h_act + HW'(H_FP + H_SW));
    vs      = (v_q >= v_act + VW'(V_FP)) && (v_q < v_act + VW'(V_FP + V_SW));
    dim     = scan_q && last_v;
    rd_addr = AW'(hsrc_q);
    rd_bank = vsrc_q[0];
  end

  p_factor_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fac_q >= 3'd2) && (fac_q <= 3'd4));
  p_factor_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> ($stable(fac_q) && $stable(scan_q)));
  p_hrep_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hsub_q < fac_q);
  p_line_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |-> (hsrc_q == SXW'(IN_W)));
  p_vrep_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vsub_q < fac_q);
  p_frame_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |-> (vsrc_q == SYW'(IN_H)));
endmodule

// File: rtl/lsc_linebuf.sv
module lsc_linebuf #(
  parameter int AW = 9
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [AW-1:0]     wr_addr,
  input  lsc_pkg::rgb_t     wr_data,
  input  logic [AW-1:0]     rd_addr,
  input  logic              rd_bank,
  output lsc_pkg::rgb_t     rd_data
);
  import lsc_pkg::*;
  localparam int DEPTH = 1 << AW;

  rgb_t q_b [2];
  logic sel_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    rgb_t mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b))) mem[wr_addr] <= wr_data;
      q_b[b] <= mem[rd_addr];
    end
  end

  always_ff @(posedge clk) sel_q <= rd_bank;
  assign rd_data = sel_q ? q_b[1] : q_b[0];
endmodule

// File: rtl/line_scaler.sv
module line_scaler #(
  parameter int IN_W = 320,
  parameter int IN_H = 240,
  parameter int H_FP = 16,
  parameter int H_SW = 96,
  parameter int H_BP = 48,
  parameter int V_FP = 10,
  parameter int V_SW = 2,
  parameter int V_BP = 33,
  parameter int AW   = $clog2(IN_W)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  scale_sel,
  input  logic        scan_en,
  input  logic        freeze,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_sol,
  input  logic [23:0] in_pix,
  output logic [23:0] out_pix,
  output logic        out_de,
  output logic        out_hsync,
  output logic        out_vsync
);
  import lsc_pkg::*;

  logic          wr_en, wr_bank, rd_bank;
  logic [AW-1:0] wr_addr, rd_addr;
  logic          de0, hs0, vs0, dim0;
  logic          de1, hs1, vs1, dim1;
  rgb_t          rd_data;

  lsc_writer #(.IN_W(IN_W), .AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_sol(in_sol), .freeze(freeze), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bank(wr_bank));

  lsc_timing #(.IN_W(IN_W), .IN_H(IN_H), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
               .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP), .AW(AW)) u_tm (
    .clk(clk), .rst_n(rst_n), .scale_sel(scale_sel), .scan_en(scan_en),
    .de(de0), .hs(hs0), .vs(vs0), .dim(dim0), .rd_addr(rd_addr), .rd_bank(rd_bank));

  lsc_linebuf #(.AW(AW)) u_buf (
    .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(in_pix), .rd_addr(rd_addr), .rd_bank(rd_bank), .rd_data(rd_data));

  // stage 1 lines up with the RAM read, stage 2 drives the ports
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {de1, hs1, vs1, dim1} <= '0;
      {out_de, out_hsync, out_vsync} <= '0;
      out_pix <= '0;
    end else begin
      {de1, hs1, vs1, dim1} <= {de0, hs0, vs0, dim0};
      out_de    <= de1;
      out_hsync <= hs1;
      out_vsync <= vs1;
      out_pix   <= de1 ? (dim1 ? shade(rd_data) : rd_data) : '0;
    end
  end

  p_freeze_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !wr_en);
  p_sync_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_de |-> (!out_hsync && !out_vsync));
endmodule

// File: tb/test_line_scaler.sv
`timescale 1ns/1ps
module test_line_scaler;
  localparam int IN_W = 6, IN_H = 4;
  localparam int H_FP = 2, H_SW = 3, H_BP = 3, V_FP = 1, V_SW = 1, V_BP = 2;
  localparam int HB = H_FP + H_SW + H_BP;

  logic clk = 0, rst_n = 0;
  logic [1:0] scale_sel = 0;
  logic scan_en = 0, freeze = 0, in_valid = 0, in_sof = 0, in_sol = 0;
  logic [23:0] in_pix = 0;
  logic [23:0] out_pix;
  logic out_de, out_hsync, out_vsync;

  always #2 clk = ~clk;

  line_scaler #(.IN_W(IN_W), .IN_H(IN_H), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
                .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP)) i_line_scaler (
    .clk(clk), .rst_n(rst_n), .scale_sel(scale_sel), .scan_en(scan_en),
    .freeze(freeze), .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol),
    .in_pix(in_pix), .out_pix(out_pix), .out_de(out_de), .out_hsync(out_hsync),
    .out_vsync(out_vsync));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [23:0] shadow [2][IN_W];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] pv(int seed, int ln, int x);
    logic [7:0] r, g, b;
    r = 8'(seed * 37 + ln * 11 + x * 3 + 17);
    g = 8'(seed * 5 + ln * 53 + x * 19 + 100);
    b = 8'(seed * 71 + x * 7 + ln * 29 + 3);
    return {r, g, b};
  endfunction

  function automatic int fac(int code);
    if (code == 0) return 2;
    if (code == 1) return 3;
    return 4;
  endfunction

  // ---------------- monitor ----------------
  bit pde = 0, phs = 0, pvs = 0, armed = 0;
  int x = 0, y = 0, yb = 0, vs_cnt = 0, hs_rises = 0;
  int since_fall = 0, hs_gap = 0, hs_len = 0, vs_len = 0;
  int cur_s = 2, nxt_s = 2;
  bit cur_scan = 0, nxt_scan = 0, cur_chk = 0, nxt_chk = 0;
  string cur_tag = "", nxt_tag = "";

  always @(negedge clk) begin
    if (rst_n) begin
      since_fall++; hs_gap++;
      if (out_hsync) hs_len++;
      if (out_vsync) vs_len++;
      if (out_de && !pde) begin
        if (yb == 0) begin
          cur_s = nxt_s; cur_scan = nxt_scan; cur_chk = nxt_chk; cur_tag = nxt_tag;
        end
        yb++; x = 0;
      end
      if (out_de) begin
        if (cur_chk) begin
          automatic int sy = y / cur_s;
          automatic int sub = y % cur_s;
          automatic logic [23:0] e = shadow[sy % 2][x / cur_s];
          automatic string tg = $sformatf("R1 R2 R7 R9 %s pixel x=%0d y=%0d", cur_tag, x, y);
          if (cur_scan && sub == cur_s - 1) begin
            e = {e[23:16] >> 1, e[15:8] >> 1, e[7:0] >> 1};
            tg = $sformatf("R6 %s", tg);
          end
          chk(out_pix === e, tg, int'(out_pix), int'(e));
        end
        x++;
      end else begin
        chk(out_pix === 24'd0, "R10 blank pixel", int'(out_pix), 0);
      end
      if (!out_de && pde) begin
        if (cur_chk) chk(x == IN_W * cur_s, {"R1 R3 width ", cur_tag}, x, IN_W * cur_s);
        y++; since_fall = 0; armed = 1;
      end
      if (out_hsync && !phs) begin
        hs_rises++;
        if (hs_rises == 2) chk(hs_gap == IN_W * 2 + HB, "R11 first line period", hs_gap, IN_W * 2 + HB);
        if (armed && cur_chk) begin
          chk(since_fall == H_FP, "R4 hsync offset", since_fall, H_FP);
          if (y >= 2) chk(hs_gap == IN_W * cur_s + HB, "R4 line period", hs_gap, IN_W * cur_s + HB);
        end
        armed = 0; hs_gap = 0;
      end
      if (!out_hsync && phs) begin
        chk(hs_len == H_SW, "R4 hsync width", hs_len, H_SW);
        hs_len = 0;
      end
      if (out_vsync && !pvs) begin
        if (cur_chk) begin
          chk(y == IN_H * cur_s, {"R2 R3 line count ", cur_tag}, y, IN_H * cur_s);
          chk(since_fall == HB + V_FP * (IN_W * cur_s + HB), "R4 vsync offset",
              since_fall, HB + V_FP * (IN_W * cur_s + HB));
        end
        y = 0; yb = 0; vs_cnt++;
      end
      if (!out_vsync && pvs) begin
        if (cur_chk) chk(vs_len == V_SW * (IN_W * cur_s + HB), "R4 vsync width",
                         vs_len, V_SW * (IN_W * cur_s + HB));
        vs_len = 0;
      end
      pde = out_de; phs = out_hsync; pvs = out_vsync;
    end
  end

  // ---------------- driver ----------------
  task automatic wait_vs();
    automatic int k = vs_cnt;
    while (vs_cnt == k) @(negedge clk);
  endtask

  // R9: two extra pixels per line beyond IN_W-1 are driven and must be dropped
  task automatic drive_line(int seed, int ln, bit frz);
    for (int c = 0; c < IN_W + 2; c++) begin
      if (c == 3) begin
        @(negedge clk); in_valid = 0; in_sof = 0; in_sol = 0; in_pix = 24'hFFFFFF;
      end
      @(negedge clk);
      in_valid = 1;
      in_sof = (ln == 0 && c == 0);
      in_sol = (c == 0);
      in_pix = pv(seed, ln, c);
      if (!frz && c < IN_W) shadow[ln % 2][c] = pv(seed, ln, c);
    end
    @(negedge clk); in_valid = 0; in_sof = 0; in_sol = 0;
  endtask

  task automatic run_frame(int code, bit scan, bit frz, int seed, int mid_code, string tag);
    automatic int s = fac(code);
    wait_vs();
    scale_sel = 2'(code); scan_en = scan; freeze = frz;
    nxt_s = s; nxt_scan = scan; nxt_chk = 1; nxt_tag = tag;
    drive_line(seed, 0, frz);
    for (int ln = 1; ln < IN_H; ln++) begin
      while (yb < (ln - 1) * s + 1) @(negedge clk);
      drive_line(seed, ln, frz);
      if (ln == 2 && mid_code >= 0) scale_sel = 2'(mid_code);
    end
  endtask

  initial begin
    // R11: reset state of the outputs
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_de === 0 && out_hsync === 0 && out_vsync === 0, "R11 syncs in reset",
          int'({out_de, out_hsync, out_vsync}), 0);
      chk(out_pix === 24'd0, "R11 pixel in reset", int'(out_pix), 0);
    end
    rst_n = 1;
    @(negedge clk);
    chk(out_de === 0 && out_pix === 24'd0, "R11 after release", int'(out_pix), 0);
    run_frame(0, 0, 0, 1, -1, "R3 code0");
    run_frame(0, 1, 0, 2, -1, "R3 code0 scan");
    run_frame(1, 0, 0, 3, -1, "R3 code1");
    run_frame(1, 1, 0, 4, -1, "R3 code1 scan");
    run_frame(2, 1, 0, 5, -1, "R3 code2 scan");
    run_frame(3, 0, 0, 6, 0, "R5 R3 code3 mid-change");
    run_frame(0, 0, 0, 7, -1, "R5 after change");
    run_frame(2, 0, 1, 8, -1, "R8 frozen");
    run_frame(2, 1, 0, 9, -1, "R8 released");
    wait_vs();
    nxt_chk = 0;
    repeat (200) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL timeout act=0x%0h exp=0x%0h", 100000, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule